// File: doc/BRIEF.md
# Transmit Packet Slot Byte Streamer

This block reads one outgoing packet out of a 32KB transmit packet RAM and hands it to a transmit PHY one byte at a time. The RAM is divided into eight fixed 4KB slots. The block reaches it through a native 64-bit read port that it drives directly, with no bus fabric in between. The controlling MAC logic names a slot, a header offset and a packet length for each transmit event, then pulses start. The header offset lets the block skip whatever metadata software keeps at the base of the slot, and it may be any byte value. The stream always opens with an 8-byte PHY header region, which begins with the SIGNAL field. The MAC payload bytes follow that region.

The block computes word addresses, issues reads, and keeps up to two words either in flight or buffered. It picks each byte from the current word by its lane. The byte output uses valid/ready. Once valid is raised it stays high, and the byte stays unchanged, until the consumer takes it with ready. The consumer may pause the stream for any number of cycles. While ready stays high, the block delivers one byte every cycle. A transfer that would run past the end of its slot is cut short at the slot boundary and flagged.

Top module: `txbuf_byte_reader`

## Requirements
- R1: After reset, `byte_valid_o`, `busy_o`, `done_o`, `err_o` and `ram_en_o` are all low.
- R2: The stream begins with the RAM byte at address slot*4096 + header offset, and the following bytes come from ascending addresses. RAM byte address a lives in bits [8*(a mod 8) +: 8] of RAM word a/8.
- R3: Each read places the word address (byte address shifted right by 3) on `ram_addr_o` while `ram_en_o` is high. The word must appear on `ram_rdata_i` in the next cycle.
- R4: A header offset that is not a multiple of 8 produces a stream that starts at the matching byte lane of the first word.
- R5: Without truncation, the stream holds exactly 8 + packet length bytes. The first 8 bytes are the PHY header region, so the payload starts at the header offset plus 8.
- R6: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o` stays high and `byte_o` keeps its value in the next cycle.
- R7: With `byte_ready_i` held high, the last byte is accepted exactly total-1 cycles after the first byte is accepted.
- R8: `done_o` is high for exactly the one cycle after the final byte is accepted. `busy_o` is low in that cycle.
- R9: A start pulse while `busy_o` is high is ignored. The running stream, its length and `err_o` do not change.
- R10: If header offset + 8 + packet length exceeds 4096, the stream stops at the last byte of the slot (4096 − header offset bytes). In that case `err_o` goes high from the cycle after start until the next accepted start; otherwise it stays low.
- R11: Every address issued with `ram_en_o` high lies inside the slot selected at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| slot_i | input | 3 | Slot index 0..7 |
| hdr_off_i | input | 12 | Byte offset of the PHY header within the slot |
| pkt_len_i | input | 12 | MAC packet length in bytes, excluding the 8-byte PHY header |
| ram_en_o | output | 1 | RAM read enable |
| ram_addr_o | output | 12 | RAM word address |
| ram_rdata_i | input | 64 | RAM read data, valid the cycle after `ram_en_o` |
| byte_o | output | 8 | Stream byte |
| byte_valid_o | output | 1 | Stream byte valid |
| byte_ready_i | input | 1 | Stream consumer ready |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the final byte is accepted |
| err_o | output | 1 | Transfer was truncated at the slot end |

## Verification
Two things can happen in the same cycle. A consumer pop can take the last byte of a word while the fetch side issues a read into the entry that the pop frees. Separately, a start pulse can arrive during a busy transfer. The first is provoked by holding ready high over unaligned offsets, so word boundaries fall at every lane. It is judged by the exact byte sequence and by the one-byte-per-cycle timing of R7. The second is provoked by pulsing start with a different slot in the middle of a packet. It is judged by the scoreboard seeing no stray bytes, an unchanged byte count and a single done pulse.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int SLOT_CNT      = 8;
  localparam int SLOT_BYTES    = 4096;
  localparam int WORD_BYTES    = 8;
  localparam int PHY_HDR_BYTES = 8;
  localparam int FETCH_DEPTH   = 2;
  localparam int SLOT_W  = $clog2(SLOT_CNT);
  localparam int OFF_W   = $clog2(SLOT_BYTES);
  localparam int LANE_W  = $clog2(WORD_BYTES);
  localparam int BADDR_W = SLOT_W + OFF_W;
  localparam int WADDR_W = BADDR_W - LANE_W;
  localparam int CNT_W   = OFF_W + 1;
  localparam int DATA_W  = 8 * WORD_BYTES;
  typedef logic [BADDR_W-1:0] baddr_t;
  typedef logic [WADDR_W-1:0] waddr_t;
  typedef logic [CNT_W-1:0]   cnt_t;
endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [OFF_W-1:0]  hdr_off_i,
  input  logic [OFF_W-1:0]  pkt_len_i,
  input  logic              last_acc_i,
  output logic              start_acc_o,
  output baddr_t            base_o,
  output cnt_t              total_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              done_o
);
  logic busy_q, err_q, done_q;
  cnt_t need, room;
  logic over;

  assign start_acc_o = start_i && !busy_q;
  assign need    = cnt_t'(PHY_HDR_BYTES) + cnt_t'(pkt_len_i);
  assign room    = cnt_t'(SLOT_BYTES) - cnt_t'(hdr_off_i);
  assign over    = need > room;
  assign total_o = over ? room : need;
  assign base_o  = {slot_i, hdr_off_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_acc_i;
      if (start_acc_o) begin
        busy_q <= 1'b1;
        err_q  <= over;
      end else if (last_acc_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign done_o = done_q;

  // R9
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i |=> $stable(err_q));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/txbuf_fetch.sv
module txbuf_fetch
  import txbuf_pkg::*;
#(
  parameter int DEPTH = FETCH_DEPTH
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_acc_i,
  input  baddr_t base_i,
  input  cnt_t   total_i,
  input  logic   pop_i,
  output logic   ram_en_o,
  output waddr_t ram_addr_o,
  output logic   push_o
);
  localparam int CR_W = $clog2(DEPTH + 1);

  waddr_t faddr, flast;
  logic   fetching, push_q, issue;
  logic [CR_W-1:0]   credits;
  logic [SLOT_W-1:0] slot_q;
  logic [BADDR_W:0]  end_byte;

  assign end_byte = {1'b0, base_i} + (BADDR_W+1)'(total_i) - 1'b1;
  assign issue    = fetching && ((credits < CR_W'(DEPTH)) || pop_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faddr    <= '0;
      flast    <= '0;
      fetching <= 1'b0;
      push_q   <= 1'b0;
      credits  <= '0;
      slot_q   <= '0;
    end else begin
      push_q  <= issue;
      credits <= credits + CR_W'(issue) - CR_W'(pop_i);
      if (start_acc_i) begin
        faddr    <= base_i[BADDR_W-1:LANE_W];
        flast    <= end_byte[BADDR_W-1:LANE_W];
        slot_q   <= base_i[BADDR_W-1 -: SLOT_W];
        fetching <= 1'b1;
      end else if (issue) begin
        faddr <= faddr + 1'b1;
        if (faddr == flast) fetching <= 1'b0;
      end
    end
  end

  assign ram_en_o   = issue;
  assign ram_addr_o = faddr;
  assign push_o     = push_q;

  // R11
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en_o |-> ram_addr_o[WADDR_W-1 -: SLOT_W] == slot_q);
  // R3
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CR_W'(DEPTH));
endmodule

// File: rtl/txbuf_word_fifo.sv
module txbuf_word_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push_i) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_i)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      occ <= occ + OW'(push_i) - OW'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= data_i;
  end

  assign head_o  = mem[rp];
  assign empty_o = (occ == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> occ < OW'(DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/txbuf_unpack.sv
module txbuf_unpack
  import txbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc_i,
  input  logic [LANE_W-1:0] base_lane_i,
  input  cnt_t              total_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              empty_i,
  input  logic              ready_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              pop_o,
  output logic              last_acc_o
);
  cnt_t              rem;
  logic [LANE_W-1:0] lane;
  logic              acc;

  assign valid_o    = (rem != '0) && !empty_i;
  assign byte_o     = head_i[int'(lane)*8 +: 8];
  assign acc        = valid_o && ready_i;
  assign last_acc_o = acc && (rem == cnt_t'(1));
  assign pop_o      = acc && ((lane == '1) || (rem == cnt_t'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      lane <= '0;
    end else if (start_acc_i) begin
      rem  <= total_i;
      lane <= base_lane_i;
    end else if (acc) begin
      rem  <= rem - 1'b1;
      lane <= lane + 1'b1;
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(byte_o));
endmodule

// File: rtl/txbuf_byte_reader.sv
module txbuf_byte_reader
  import txbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [OFF_W-1:0]  hdr_off_i,
  input  logic [OFF_W-1:0]  pkt_len_i,
  output logic              ram_en_o,
  output logic [WADDR_W-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic   start_acc, last_acc, pop, push, empty;
  baddr_t base;
  cnt_t   total;
  logic [DATA_W-1:0] head;

  txbuf_ctrl ctrl_i (
    .clk, .rst_n, .start_i, .slot_i, .hdr_off_i, .pkt_len_i,
    .last_acc_i(last_acc), .start_acc_o(start_acc), .base_o(base),
    .total_o(total), .busy_o, .err_o, .done_o
  );

  txbuf_fetch #(.DEPTH(FETCH_DEPTH)) fetch_i (
    .clk, .rst_n, .start_acc_i(start_acc), .base_i(base), .total_i(total),
    .pop_i(pop), .ram_en_o, .ram_addr_o, .push_o(push)
  );

  txbuf_word_fifo #(.DEPTH(FETCH_DEPTH), .W(DATA_W)) fifo_i (
    .clk, .rst_n, .push_i(push), .data_i(ram_rdata_i), .pop_i(pop),
    .head_o(head), .empty_o(empty)
  );

  txbuf_unpack unpack_i (
    .clk, .rst_n, .start_acc_i(start_acc), .base_lane_i(base[LANE_W-1:0]),
    .total_i(total), .head_i(head), .empty_i(empty), .ready_i(byte_ready_i),
    .byte_o, .valid_o(byte_valid_o), .pop_o(pop), .last_acc_o(last_acc)
  );

  // R8
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> busy_o);
endmodule

// File: tb/txbuf_byte_reader_tb.sv
module txbuf_byte_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  slot = '0;
  logic [11:0] off = '0;
  logic [11:0] len = '0;
  logic        ram_en;
  logic [11:0] ram_addr;
  logic [63:0] ram_rdata = '0;
  logic [7:0]  byte_d;
  logic        valid, ready = 1'b0, busy, done, err;

  int checks = 0, fails = 0, cyc = 0;
  int rmode = 0;
  logic [7:0] exp_q[$];
  int acc_n = 0, first_cyc = -1, last_cyc = -1;
  logic exp_done = 1'b0, pkt_fin = 1'b0, hold_pend = 1'b0;
  logic [7:0] hold_byte = '0;
  logic [2:0] cur_slot = '0;

  always #5 clk = ~clk;

  txbuf_byte_reader dut_i (
    .clk, .rst_n, .start_i(start), .slot_i(slot), .hdr_off_i(off),
    .pkt_len_i(len), .ram_en_o(ram_en), .ram_addr_o(ram_addr),
    .ram_rdata_i(ram_rdata), .byte_o(byte_d), .byte_valid_o(valid),
    .byte_ready_i(ready), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [7:0] pat(logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5A;
  endfunction

  // RAM model: one-cycle read latency, little-endian byte lanes (R2, R3)
  always @(posedge clk) begin
    if (ram_en)
      for (int l = 0; l < 8; l++) ram_rdata[l*8 +: 8] <= pat({ram_addr, 3'(l)});
  end

  always @(posedge clk) begin
    #2;
    ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (hold_pend) chk(valid && byte_d == hold_byte, "R6 hold", {valid, byte_d}, {1'b1, hold_byte});
      hold_pend = valid && !ready;
      hold_byte = byte_d;
      if (exp_done) begin
        chk(done && !busy, "R8 done pulse", {done, busy}, 2);
        exp_done = 1'b0;
        pkt_fin  = 1'b1;
      end else if (done) begin
        chk(1'b0, "R8 stray done", 1, 0);
      end
      if (ram_en) chk(ram_addr[11:9] == cur_slot, "R11 slot bound", ram_addr[11:9], cur_slot);
      if (valid && ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 extra byte", byte_d, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(byte_d == e, "R2 R4 R5 byte", byte_d, e);
          acc_n++;
          if (first_cyc < 0) first_cyc = cyc;
          last_cyc = cyc;
          if (exp_q.size() == 0) exp_done = 1'b1;
        end
      end
    end
  end

  task automatic run_pkt(input int s, input int o, input int l, input int mode, input bit inject);
    int need, room, tot;
    bit ov;
    need = 8 + l;
    room = 4096 - o;
    ov   = need > room;
    tot  = ov ? room : need;
    for (int i = 0; i < tot; i++) exp_q.push_back(pat(15'(s * 4096 + o + i)));
    acc_n = 0; first_cyc = -1; last_cyc = -1; pkt_fin = 1'b0;
    rmode = mode;
    cur_slot = 3'(s);
    @(posedge clk); #2;
    slot = 3'(s); off = 12'(o); len = 12'(l); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(err == ov, "R10 err flag", err, ov);
    chk(busy, "R8 busy after start", busy, 1);
    if (inject) begin
      repeat (5) @(posedge clk);
      #2; slot = 3'd6; off = 12'd0; len = 12'd5; start = 1'b1;
      @(posedge clk); #2; start = 1'b0;
      @(negedge clk);
      chk(err == ov, "R9 err unchanged", err, ov);
    end
    for (int t = 0; t < 20000 && !pkt_fin; t++) @(negedge clk);
    chk(pkt_fin, "R8 packet completion", pkt_fin, 1);
    chk(acc_n == tot, "R5 R10 byte count", acc_n, tot);
    if (mode == 0) chk(last_cyc - first_cyc == tot - 1, "R7 throughput", last_cyc - first_cyc, tot - 1);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !valid, "R8 idle after done", {busy, done, valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!valid && !busy && !done && !err && !ram_en, "R1 reset state",
        {valid, busy, done, err, ram_en}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !busy && !ram_en, "R1 after reset", {valid, busy, ram_en}, 0);
    run_pkt(0, 0, 20, 0, 0);        // R2 R5 aligned, full rate
    run_pkt(3, 48, 100, 1, 0);      // R6 random back-pressure
    run_pkt(5, 13, 37, 0, 0);       // R4 unaligned offset
    run_pkt(7, 4093, 0, 0, 0);      // R10 truncation to 3 bytes
    run_pkt(2, 4000, 200, 1, 0);    // R10 truncation with stalls
    run_pkt(1, 7, 60, 0, 1);        // R9 start while busy
    run_pkt(6, 0, 0, 0, 0);         // R5 header-only stream
    run_pkt(4, 1023, 77, 1, 0);     // R4 lane 7 start with stalls
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule